// File: doc/BRIEF.md
# Idle-Driven Power-Zone Controller

This block governs a single independently switchable power zone of a processor core, for example a vector register file. A saturating counter measures how many cycles have passed since the zone was last used. It is compared against a threshold that the operating system programs. When the threshold is strictly below the idle count, the zone is switched off. If a use arrives while the zone is off or still powering up, the block raises a fault instead of serving it. It can also start the wake sequence on its own. The zone returns to service only after a minimum settle time and a power-good indication from the supply.

Because the comparison is strict, the threshold alone selects the policy. All-ones keeps the zone on for good, because a saturated counter can never exceed it. Zero drops the zone on the second idle cycle after use ends. Any value in between acts as an idle timeout. Each power-up saves the idle count from just before the wake into a snapshot register, so software can see when a zone was woken soon after being switched off. The three registers can be reached only from privileged mode.

Top module: `zone_idle_pwrctl`

## Requirements
- R1: The idle counter is CNT_W bits wide (32 by default) and saturates at all-ones instead of wrapping to zero.
- R2: On every clock edge with no serviced use and no power-up, the idle counter advances by one, in every power state.
- R3: A use request while the zone is on (use_ready high) clears the idle counter to 0 at that edge.
- R4: On the edge where the zone finishes waking and turns on, the idle counter is cleared to 0.
- R5: While on, if no use is requested and threshold < idle count, the zone is off after the next edge (use_ready and pwr_en low).
- R6: A threshold of all-ones never switches the zone off. When the zone is off and the threshold is not below the idle count, the zone starts waking.
- R7: With a threshold of 0, the zone stays on while use is held, stays on after the first idle edge, and is off after the second idle edge.
- R8: On the edge where the zone turns on, the idle count held just before that edge is copied into the snapshot register.
- R9: After reset the zone is on, the idle count and snapshot are 0, and the threshold reads 10000 (CMP_RESET).
- R10: Register index 0 is the idle count, 1 the threshold, and 2 the snapshot. Only index 1 is writable. Any access with priv low, a write to any index other than 1, or a read of index 3 sets reg_err, returns reg_rdata of 0 and changes nothing.
- R11: A use request while the zone is not on raises use_fault in the same cycle and is not served. With AUTO_WAKE set, it moves an off zone to the waking state.
- R12: The zone stays in the waking state for at least WAKE_CYCLES edges and until pwr_good is high. pwr_en is high while waking or on and low while off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| use_req | input | 1 | Zone use request this cycle |
| use_ready | output | 1 | Zone is on and serves the use |
| use_fault | output | 1 | Use request refused because the zone is not on |
| pwr_en | output | 1 | Request to the power switch to supply the zone |
| pwr_good | input | 1 | Supply reports the zone rail is stable |
| priv | input | 1 | Access is made in privileged mode |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register index: 0 count, 1 threshold, 2 snapshot |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data, combinational, 0 when not valid |
| reg_err | output | 1 | Access refused |

## Verification
On every cycle, the assertions check several relations. The counter never wraps from all-ones. A served use clears it. A power-up clears it and fills the snapshot. A strict threshold crossing turns the zone off on the next edge, and an all-ones threshold holds it on. A refused use always shows a fault, and the zone never reports ready with its supply off or before power-good. Some behaviours can only be shown by the bench's scenarios: the exact 10000-cycle default timeout, the wake latency of WAKE_CYCLES edges, the stall on a late power-good, the wake caused by raising the threshold, and the refusal of unprivileged or misdirected register accesses.

// File: rtl/zpc_pkg.sv
package zpc_pkg;

   typedef enum logic [1:0] {
      ZS_ON     = 2'd0,
      ZS_OFF    = 2'd1,
      ZS_WAKING = 2'd2
   } zone_state_e;

   localparam logic [1:0] SEL_COUNT = 2'd0;
   localparam logic [1:0] SEL_LIMIT = 2'd1;
   localparam logic [1:0] SEL_SNAP  = 2'd2;

endpackage

// File: rtl/zpc_idle_counter.sv
module zpc_idle_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   output logic [CNT_W-1:0] count
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clear) begin
         count <= '0;
      end else if (count != CNT_MAX) begin
         count <= count + CNT_ONE;
      end
   end

endmodule

// File: rtl/zpc_power_fsm.sv
module zpc_power_fsm
   import zpc_pkg::*;
#(
   parameter int WAKE_CYCLES = 4,
   parameter bit AUTO_WAKE   = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        use_req,
   input  logic        over_limit,
   input  logic        pwr_good,
   output zone_state_e state,
   output logic        power_up
);

   localparam int WW = (WAKE_CYCLES > 1) ? $clog2(WAKE_CYCLES) : 1;
   localparam logic [WW-1:0] WAIT_LAST = WW'(WAKE_CYCLES - 1);

   zone_state_e    state_nx;
   logic [WW-1:0]  wait_cnt;
   logic           wait_done;
   logic           wake_trig;

   generate
      if (AUTO_WAKE) begin : g_auto_wake
         assign wake_trig = use_req || !over_limit;
      end else begin : g_os_wake
         assign wake_trig = !over_limit;
      end
   endgenerate

   assign wait_done = (wait_cnt == WAIT_LAST);
   assign power_up  = (state == ZS_WAKING) && wait_done && pwr_good;

   always_comb begin
      state_nx = state;
      unique case (state)
         ZS_ON:     if (!use_req && over_limit) state_nx = ZS_OFF;
         ZS_OFF:    if (wake_trig)              state_nx = ZS_WAKING;
         ZS_WAKING: if (power_up)               state_nx = ZS_ON;
         default:                               state_nx = ZS_OFF;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ZS_ON;
      end else begin
         state <= state_nx;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wait_cnt <= '0;
      end else if (state != ZS_WAKING) begin
         wait_cnt <= '0;
      end else if (!wait_done) begin
         wait_cnt <= wait_cnt + WW'(1);
      end
   end

endmodule

// File: rtl/zpc_csr.sv
module zpc_csr
   import zpc_pkg::*;
#(
   parameter int          CNT_W     = 32,
   parameter int unsigned CMP_RESET = 10000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             priv,
   input  logic             rd,
   input  logic             wr,
   input  logic [1:0]       sel,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] rdata,
   output logic             err,
   input  logic [CNT_W-1:0] idle_cnt,
   input  logic             power_up,
   output logic [CNT_W-1:0] cmp_val,
   output logic [CNT_W-1:0] prev_cnt
);

   localparam logic [CNT_W-1:0] CMP_INIT = CNT_W'(CMP_RESET);

   logic bad_sel;
   logic wr_ok;
   logic [CNT_W-1:0] sel_data;

   assign bad_sel = (wr && sel != SEL_LIMIT) || (rd && sel == 2'd3);
   assign err     = (rd || wr) && (!priv || bad_sel);
   assign wr_ok   = wr && !err;

   always_comb begin
      unique case (sel)
         SEL_COUNT: sel_data = idle_cnt;
         SEL_LIMIT: sel_data = cmp_val;
         SEL_SNAP:  sel_data = prev_cnt;
         default:   sel_data = '0;
      endcase
   end

   assign rdata = (rd && !err) ? sel_data : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_val <= CMP_INIT;
      end else if (wr_ok) begin
         cmp_val <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_cnt <= '0;
      end else if (power_up) begin
         prev_cnt <= idle_cnt;
      end
   end

endmodule

// File: rtl/zone_idle_pwrctl.sv
module zone_idle_pwrctl
   import zpc_pkg::*;
#(
   parameter int          CNT_W       = 32,
   parameter int unsigned CMP_RESET   = 10000,
   parameter int          WAKE_CYCLES = 4,
   parameter bit          AUTO_WAKE   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             use_req,
   output logic             use_ready,
   output logic             use_fault,
   output logic             pwr_en,
   input  logic             pwr_good,
   input  logic             priv,
   input  logic             reg_rd,
   input  logic             reg_wr,
   input  logic [1:0]       reg_sel,
   input  logic [CNT_W-1:0] reg_wdata,
   output logic [CNT_W-1:0] reg_rdata,
   output logic             reg_err
);

   generate
      if (CNT_W < 8 || CNT_W > 63) begin : g_bad_width
         $error("zone_idle_pwrctl: CNT_W must lie in 8..63");
      end
      if (64'(CMP_RESET) > ((64'd1 << CNT_W) - 64'd1)) begin : g_bad_reset
         $error("zone_idle_pwrctl: CMP_RESET does not fit in CNT_W bits");
      end
      if (WAKE_CYCLES < 1) begin : g_bad_wake
         $error("zone_idle_pwrctl: WAKE_CYCLES must be at least 1");
      end
   endgenerate

   zone_state_e      state;
   logic             power_up;
   logic             cnt_clear;
   logic             over_limit;
   logic [CNT_W-1:0] idle_cnt;
   logic [CNT_W-1:0] cmp_val;
   logic [CNT_W-1:0] prev_cnt;

   assign over_limit = (cmp_val < idle_cnt);
   assign cnt_clear  = power_up || (state == ZS_ON && use_req);

   zpc_idle_counter #(
      .CNT_W (CNT_W)
   ) u_counter (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (cnt_clear),
      .count (idle_cnt)
   );

   zpc_power_fsm #(
      .WAKE_CYCLES (WAKE_CYCLES),
      .AUTO_WAKE   (AUTO_WAKE)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .use_req    (use_req),
      .over_limit (over_limit),
      .pwr_good   (pwr_good),
      .state      (state),
      .power_up   (power_up)
   );

   zpc_csr #(
      .CNT_W     (CNT_W),
      .CMP_RESET (CMP_RESET)
   ) u_csr (
      .clk      (clk),
      .rst_n    (rst_n),
      .priv     (priv),
      .rd       (reg_rd),
      .wr       (reg_wr),
      .sel      (reg_sel),
      .wdata    (reg_wdata),
      .rdata    (reg_rdata),
      .err      (reg_err),
      .idle_cnt (idle_cnt),
      .power_up (power_up),
      .cmp_val  (cmp_val),
      .prev_cnt (prev_cnt)
   );

   assign use_ready = (state == ZS_ON);
   assign use_fault = use_req && (state != ZS_ON);
   assign pwr_en    = (state != ZS_OFF);

endmodule

// File: rtl/zone_idle_pwrctl_chk.sv
module zone_idle_pwrctl_chk #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             use_req,
   input logic             use_ready,
   input logic             use_fault,
   input logic             pwr_en,
   input logic             pwr_good,
   input logic [CNT_W-1:0] idle_cnt,
   input logic [CNT_W-1:0] cmp_val,
   input logic [CNT_W-1:0] prev_cnt
);

   localparam logic [CNT_W-1:0] ALL_ONES = '1;

   a_r1_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(idle_cnt) == ALL_ONES) |-> (idle_cnt == ALL_ONES || idle_cnt == '0));

   a_r3_use_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (use_req && use_ready) |=> (idle_cnt == '0));

   a_r4_r8_power_on: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(use_ready) |-> (idle_cnt == '0 && prev_cnt == $past(idle_cnt)));

   a_r5_power_down: assert property (@(posedge clk) disable iff (!rst_n)
      (use_ready && !use_req && cmp_val < idle_cnt) |=> !use_ready);

   a_r6_force_on: assert property (@(posedge clk) disable iff (!rst_n)
      (use_ready && cmp_val == ALL_ONES) |=> use_ready);

   a_r11_fault: assert property (@(posedge clk) disable iff (!rst_n)
      (use_req && !use_ready) |-> use_fault);

   a_r11_no_fault_when_on: assert property (@(posedge clk) disable iff (!rst_n)
      use_fault |-> !use_ready);

   a_r12_supply: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_en |-> !use_ready);

   a_r12_power_good: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(use_ready) |-> $past(pwr_good));

endmodule

bind zone_idle_pwrctl zone_idle_pwrctl_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .use_req   (use_req),
   .use_ready (use_ready),
   .use_fault (use_fault),
   .pwr_en    (pwr_en),
   .pwr_good  (pwr_good),
   .idle_cnt  (idle_cnt),
   .cmp_val   (cmp_val),
   .prev_cnt  (prev_cnt)
);

// File: tb/zone_idle_pwrctl_test.sv
module zone_idle_pwrctl_test;

   localparam int CNT_W = 16;
   localparam logic [CNT_W-1:0] ONES = '1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             use_req = 1'b0;
   logic             use_ready;
   logic             use_fault;
   logic             pwr_en;
   logic             pwr_good = 1'b1;
   logic             priv = 1'b1;
   logic             reg_rd = 1'b0;
   logic             reg_wr = 1'b0;
   logic [1:0]       reg_sel = 2'd0;
   logic [CNT_W-1:0] reg_wdata = '0;
   logic [CNT_W-1:0] reg_rdata;
   logic             reg_err;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   zone_idle_pwrctl #(
      .CNT_W       (CNT_W),
      .CMP_RESET   (10000),
      .WAKE_CYCLES (4),
      .AUTO_WAKE   (1'b1)
   ) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .use_req   (use_req),
      .use_ready (use_ready),
      .use_fault (use_fault),
      .pwr_en    (pwr_en),
      .pwr_good  (pwr_good),
      .priv      (priv),
      .reg_rd    (reg_rd),
      .reg_wr    (reg_wr),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .reg_err   (reg_err)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd(logic [1:0] sel, output logic [CNT_W-1:0] val, output logic e);
      reg_sel = sel;
      reg_rd  = 1'b1;
      #1;
      val = reg_rdata;
      e   = reg_err;
      reg_rd = 1'b0;
   endtask

   task automatic wr(logic [1:0] sel, logic [CNT_W-1:0] d);
      reg_sel   = sel;
      reg_wdata = d;
      reg_wr    = 1'b1;
      tick(1);
      reg_wr    = 1'b0;
   endtask

   task automatic t_reset;
      logic [CNT_W-1:0] v;
      logic e;
      chk("R9 ready after reset", 32'(use_ready), 1);
      chk("R9 pwr_en after reset", 32'(pwr_en), 1);
      chk("R9 no fault after reset", 32'(use_fault), 0);
      rd(2'd1, v, e);
      chk("R9 threshold default", 32'(v), 10000);
      rd(2'd2, v, e);
      chk("R9 snapshot zero", 32'(v), 0);
   endtask

   task automatic t_priv;
      logic [CNT_W-1:0] v;
      logic e;
      priv = 1'b0;
      rd(2'd0, v, e);
      chk("R10 unpriv read err", 32'(e), 1);
      chk("R10 unpriv read data", 32'(v), 0);
      reg_sel = 2'd1; reg_wdata = 16'd5; reg_wr = 1'b1;
      #1;
      chk("R10 unpriv write err", 32'(reg_err), 1);
      tick(1);
      reg_wr = 1'b0;
      priv = 1'b1;
      rd(2'd1, v, e);
      chk("R10 threshold unchanged", 32'(v), 10000);
      rd(2'd3, v, e);
      chk("R10 index 3 read err", 32'(e), 1);
      reg_sel = 2'd0; reg_wr = 1'b1;
      #1;
      chk("R10 count write err", 32'(reg_err), 1);
      tick(1);
      reg_wr = 1'b0;
   endtask

   task automatic t_count;
      logic [CNT_W-1:0] a, b;
      logic e;
      rd(2'd0, a, e);
      tick(5);
      rd(2'd0, b, e);
      chk("R2 count advance", 32'(b - a), 5);
   endtask

   task automatic t_use;
      logic [CNT_W-1:0] v;
      logic e;
      use_req = 1'b1;
      tick(1);
      rd(2'd0, v, e);
      chk("R3 use clears count", 32'(v), 0);
      chk("R11 no fault when on", 32'(use_fault), 0);
      tick(2);
      rd(2'd0, v, e);
      chk("R3 held use keeps zero", 32'(v), 0);
   endtask

   task automatic t_default_timeout;
      use_req = 1'b1;
      tick(1);
      use_req = 1'b0;
      tick(10001);
      chk("R5 on at count 10000", 32'(use_ready), 1);
      tick(1);
      chk("R5 off after crossing", 32'(use_ready), 0);
      chk("R12 pwr_en low when off", 32'(pwr_en), 0);
   endtask

   task automatic t_wake_gated;
      logic [CNT_W-1:0] v, snap, c;
      logic e;
      pwr_good = 1'b0;
      use_req = 1'b1;
      #1;
      chk("R11 fault while off", 32'(use_fault), 1);
      chk("R11 not ready while off", 32'(use_ready), 0);
      tick(1);
      use_req = 1'b0;
      wr(2'd1, ONES);
      tick(8);
      chk("R12 waits for power good", 32'(use_ready), 0);
      chk("R12 pwr_en while waking", 32'(pwr_en), 1);
      rd(2'd0, v, e);
      pwr_good = 1'b1;
      tick(1);
      chk("R12 on after power good", 32'(use_ready), 1);
      rd(2'd2, snap, e);
      chk("R8 snapshot of count", 32'(snap), 32'(v));
      rd(2'd0, c, e);
      chk("R4 count cleared at power on", 32'(c), 0);
   endtask

   task automatic t_latency;
      wr(2'd1, '0);
      tick(3);
      chk("R5 off with zero threshold", 32'(use_ready), 0);
      use_req = 1'b1;
      tick(1);
      use_req = 1'b0;
      wr(2'd1, ONES);
      tick(2);
      chk("R12 still waking at 4th edge", 32'(use_ready), 0);
      chk("R12 pwr_en during wake", 32'(pwr_en), 1);
      tick(1);
      chk("R12 on after WAKE_CYCLES", 32'(use_ready), 1);
   endtask

   task automatic t_zero_and_force;
      use_req = 1'b1;
      wr(2'd1, '0);
      tick(3);
      chk("R7 on while used", 32'(use_ready), 1);
      use_req = 1'b0;
      tick(1);
      chk("R7 on after first idle edge", 32'(use_ready), 1);
      tick(1);
      chk("R7 off after second idle edge", 32'(use_ready), 0);
      wr(2'd1, ONES);
      chk("R6 still off at write edge", 32'(use_ready), 0);
      tick(5);
      chk("R6 all-ones wakes zone", 32'(use_ready), 1);
      tick(200);
      chk("R6 stays on", 32'(use_ready), 1);
   endtask

   task automatic t_saturate;
      logic [CNT_W-1:0] v;
      logic e;
      tick(65600);
      rd(2'd0, v, e);
      chk("R1 count saturates", 32'(v), 32'(ONES));
      tick(10);
      rd(2'd0, v, e);
      chk("R1 no wrap", 32'(v), 32'(ONES));
      chk("R6 on when saturated", 32'(use_ready), 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      tick(4);
      rst_n = 1'b1;
      tick(1);
      t_reset();
      t_priv();
      t_count();
      t_use();
      t_default_timeout();
      t_wake_gated();
      t_latency();
      t_zero_and_force();
      t_saturate();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule